// File: doc/BRIEF.md
# PCI Interrupt Pin Router

The router takes the four level-sensitive interrupt pins of a PCI bus (A, B, C, D) and drives them onto a bank of sixteen ISA-style interrupt request lines. Software sets the routing at run time through a byte-wide register port. Three configuration bytes hold a 4-bit routing code for each pin, and each code names the index of the output line that the pin drives.

The routing codes sit at fixed, irregular nibble positions:

| Pin | Byte address | Bits |
|-----|--------------|------|
| A | 0x55 | [7:4] |
| B | 0x56 | [3:0] |
| C | 0x56 | [7:4] |
| D | 0x57 | [7:4] |

The lower nibbles of 0x55 and 0x57 are stored and can be read back, but they do not affect routing.

Several pins may point at the same line. That line is then the OR of their levels. Outputs are registered, so every input change or routing write shows up on the lines exactly one clock later.

Top module: `pirq_router`

## Requirements
- R1: After a synchronous active-high reset, all three configuration bytes read 0x00 and every output line is low.
- R2: A write (`cfg_we` high at a rising edge) to address 0x55, 0x56 or 0x57 stores the full byte. `cfg_rdata` returns the stored byte combinationally while `cfg_addr` selects that address.
- R3: Any other address reads 0x00, and a write to it changes neither the stored bytes nor the output lines.
- R4: Pin A (`pci_int[0]`) is routed by bits [7:4] of byte 0x55.
- R5: Pin B (`pci_int[1]`) is routed by bits [3:0] of byte 0x56, and pin C (`pci_int[2]`) by bits [7:4] of byte 0x56.
- R6: Pin D (`pci_int[3]`) is routed by bits [7:4] of byte 0x57. Bits [3:0] of bytes 0x55 and 0x57 have no effect on any output.
- R7: Output line k is high when at least one pin that is high has a routing code equal to k. This includes the case where all four pins share one line.
- R8: A line with no high pin routed to it is driven low.
- R9: Outputs are registered. A pin change or routing write before rising edge T is visible just after edge T (for pins) or T+1 (for writes), and never within the same cycle.
- R10: When a write moves a pin off a line, the old line drops one clock after the new routing takes effect, unless another high pin still routes to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_we | input | 1 | Configuration write enable |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| pci_int | input | 4 | PCI interrupt levels, bit 0 = A through bit 3 = D, active high |
| isa_irq | output | 16 | Routed interrupt request lines, bit k = line k |

## Verification
The bench goes after the nibble positions by steering one pin at a time to distinct lines and by rewriting the unused lower nibbles. A design that read the wrong half of a byte would light the wrong line or move a pin when a lower nibble changed. All four pins are placed on one line and then released one by one, which catches a merge that keeps only the last pin instead of ORing them. Re-routing a pin while a partner stays on the old line, and then moving the partner away, catches designs that fail to clear a vacated line or that clear it wrongly. Checking each output both within the cycle of a change and after the next edge catches a combinational path or an extra pipeline stage.

// File: rtl/pirq_route_pkg.sv
`timescale 1ns/1ps
package pirq_route_pkg;

    localparam int NUM_PINS  = 4;
    localparam int NUM_LINES = 16;
    localparam int CODE_W    = $clog2(NUM_LINES);
    localparam int BYTE_W    = 8;

    // Fixed decode addresses of the three routing bytes
    localparam logic [BYTE_W-1:0] ADDR_RT_A  = 8'h55;
    localparam logic [BYTE_W-1:0] ADDR_RT_BC = 8'h56;
    localparam logic [BYTE_W-1:0] ADDR_RT_D  = 8'h57;

    typedef logic [CODE_W-1:0]    route_code_t;
    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef struct packed {
        logic [BYTE_W-1:0] rt_a;
        logic [BYTE_W-1:0] rt_bc;
        logic [BYTE_W-1:0] rt_d;
    } route_cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_A,
        SEL_BC,
        SEL_D
    } cfg_sel_e;

    function automatic cfg_sel_e decode_addr(input logic [BYTE_W-1:0] addr);
        cfg_sel_e sel;
        unique case (addr)
            ADDR_RT_A:  sel = SEL_A;
            ADDR_RT_BC: sel = SEL_BC;
            ADDR_RT_D:  sel = SEL_D;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    // Nibble position of each pin's code; the positions are irregular
    function automatic route_code_t pin_code(input route_cfg_t cfg, input int pin);
        route_code_t code;
        case (pin)
            0:       code = cfg.rt_a[7:4];
            1:       code = cfg.rt_bc[3:0];
            2:       code = cfg.rt_bc[7:4];
            3:       code = cfg.rt_d[7:4];
            default: code = '0;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
`timescale 1ns/1ps
module pirq_cfg_regs
    import pirq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we,
    output logic [BYTE_W-1:0] rdata,
    output route_cfg_t        cfg
);
    cfg_sel_e sel;

    assign sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (sel)
                SEL_A:   cfg.rt_a  <= wdata;
                SEL_BC:  cfg.rt_bc <= wdata;
                SEL_D:   cfg.rt_d  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_A:   rdata = cfg.rt_a;
            SEL_BC:  rdata = cfg.rt_bc;
            SEL_D:   rdata = cfg.rt_d;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pirq_pin_decode.sv
`timescale 1ns/1ps
module pirq_pin_decode #(
    parameter int LINES = 16,
    localparam int CW   = $clog2(LINES)
) (
    input  logic [CW-1:0]    code,
    input  logic             level,
    output logic [LINES-1:0] hit
);
    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign hit[k] = level && (code == CW'(k));
    end
endmodule

// File: rtl/pirq_line_merge.sv
`timescale 1ns/1ps
module pirq_line_merge #(
    parameter int PINS  = 4,
    parameter int LINES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [PINS-1:0][LINES-1:0]  hits,
    output logic [LINES-1:0]            lines
);
    logic [LINES-1:0] merged;

    always_comb begin
        merged = '0;
        for (int p = 0; p < PINS; p++) begin
            merged = merged | hits[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lines <= '0;
        else     lines <= merged;
    end
endmodule

// File: rtl/pirq_router.sv
`timescale 1ns/1ps
module pirq_router
    import pirq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BYTE_W-1:0]    cfg_addr,
    input  logic [BYTE_W-1:0]    cfg_wdata,
    input  logic                 cfg_we,
    output logic [BYTE_W-1:0]    cfg_rdata,
    input  logic [NUM_PINS-1:0]  pci_int,
    output logic [NUM_LINES-1:0] isa_irq
);
    route_cfg_t                         cfg_q;
    logic [NUM_PINS-1:0][NUM_LINES-1:0] pin_hits;
    logic [NUM_PINS*CODE_W-1:0]         pin_codes_flat;

    pirq_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .we    (cfg_we),
        .rdata (cfg_rdata),
        .cfg   (cfg_q)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        route_code_t code;
        assign code = pin_code(cfg_q, p);
        assign pin_codes_flat[p*CODE_W +: CODE_W] = code;

        pirq_pin_decode #(.LINES(NUM_LINES)) u_dec (
            .code  (code),
            .level (pci_int[p]),
            .hit   (pin_hits[p])
        );
    end

    pirq_line_merge #(.PINS(NUM_PINS), .LINES(NUM_LINES)) u_merge (
        .clk   (clk),
        .rst   (rst),
        .hits  (pin_hits),
        .lines (isa_irq)
    );
endmodule

// File: rtl/pirq_router_chk.sv
`timescale 1ns/1ps
module pirq_router_chk
    import pirq_route_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [BYTE_W-1:0]          cfg_addr,
    input logic [BYTE_W-1:0]          cfg_wdata,
    input logic                       cfg_we,
    input logic [BYTE_W-1:0]          cfg_rdata,
    input logic [NUM_PINS-1:0]        pci_int,
    input logic [NUM_LINES-1:0]       isa_irq,
    input logic [NUM_PINS*CODE_W-1:0] pin_codes
);
    logic in_map;
    assign in_map = (cfg_addr == ADDR_RT_A) || (cfg_addr == ADDR_RT_BC) ||
                    (cfg_addr == ADDR_RT_D);

    AST_RESET_CLEARS_LINES: assert property (@(posedge clk) rst |=> isa_irq == '0); // R1

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        cfg_we && in_map |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata))); // R2

    AST_UNMAPPED_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !in_map |-> cfg_rdata == '0); // R3

    AST_LINES_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        $countones(isa_irq) <= $countones($past(pci_int))); // R8

    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(pci_int) == '0 |-> isa_irq == '0); // R8

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
        AST_PIN_REACHES_LINE: assert property (@(posedge clk) disable iff (rst)
            $past(pci_int[p]) && !$past(rst) |->
                isa_irq[$past(pin_codes[p*CODE_W +: CODE_W])]); // R7
    end
endmodule

bind pirq_router pirq_router_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .pci_int   (pci_int),
    .isa_irq   (isa_irq),
    .pin_codes (pin_codes_flat)
);

// File: tb/pirq_router_tb_top.sv
`timescale 1ns/1ps
module pirq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        cfg_we;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pci_int;
    logic [15:0] isa_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int          mcfg[3];       // bytes at 0x55, 0x56, 0x57
    logic [15:0] exp_cur;

    always #5 clk = ~clk;

    pirq_router dut_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .pci_int(pci_int), .isa_irq(isa_irq)
    );

    function automatic int model_read(input logic [7:0] a);
        if (a >= 8'h55 && a <= 8'h57) return mcfg[a - 8'h55];
        return 0;
    endfunction

    function automatic int code_of(input int pin);
        case (pin)
            0: return (mcfg[0] >> 4) & 15;
            1: return mcfg[1] & 15;
            2: return (mcfg[1] >> 4) & 15;
            default: return (mcfg[2] >> 4) & 15;
        endcase
    endfunction

    function automatic logic [15:0] model_lines(input logic [3:0] pins);
        logic [15:0] r = '0;
        for (int line = 0; line < 16; line++)
            for (int pin = 0; pin < 4; pin++)
                if (pins[pin] && code_of(pin) == line) r[line] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check, clock, check registered result
    task automatic step(input logic [7:0] a, input logic [7:0] d, input bit we,
                        input logic [3:0] pins, input string tag);
        logic [15:0] exp_next;
        cfg_addr = a; cfg_wdata = d; cfg_we = we; pci_int = pins;
        #1;
        check("R9", "same-cycle isa_irq", int'(isa_irq), int'(exp_cur));
        check(tag, "cfg_rdata", int'(cfg_rdata), model_read(a));
        exp_next = model_lines(pins);
        @(posedge clk);
        if (we && a >= 8'h55 && a <= 8'h57) mcfg[a - 8'h55] = int'(d);
        @(negedge clk);
        check(tag, "isa_irq", int'(isa_irq), int'(exp_next));
        exp_cur = exp_next;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [3:0] pins,
                      input string tag);
        step(a, d, 1'b1, pins, tag);
    endtask

    task automatic hold(input logic [3:0] pins, input string tag);
        step(8'h00, 8'h00, 1'b0, pins, tag);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_addr = '0; cfg_wdata = '0; cfg_we = 1'b0; pci_int = '0;
        for (int i = 0; i < 3; i++) mcfg[i] = 0;
        exp_cur = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "isa_irq after reset", int'(isa_irq), 0);
        for (int a = 8'h55; a <= 8'h57; a++) begin
            step(8'(a), 8'h00, 1'b0, 4'h0, "R1");
        end
        // R2: full byte write and readback
        wr(8'h55, 8'h3A, 4'h0, "R2"); hold(4'h0, "R2");
        step(8'h55, 8'h00, 1'b0, 4'h0, "R2");
        wr(8'h56, 8'hC5, 4'h0, "R2");
        step(8'h56, 8'h00, 1'b0, 4'h0, "R2");
        wr(8'h57, 8'hE7, 4'h0, "R2");
        step(8'h57, 8'h00, 1'b0, 4'h0, "R2");
        // R3: other addresses read zero, writes ignored
        wr(8'h54, 8'hFF, 4'hF, "R3");
        wr(8'h58, 8'hFF, 4'hF, "R3");
        wr(8'h00, 8'hFF, 4'hF, "R3");
        step(8'h54, 8'h00, 1'b0, 4'hF, "R3");
        for (int a = 8'h55; a <= 8'h57; a++) step(8'(a), 8'h00, 1'b0, 4'hF, "R3");
        hold(4'h0, "R3");
        // R4: pin A through 0x55[7:4]
        wr(8'h55, 8'h70, 4'h0, "R4");
        hold(4'h1, "R4"); hold(4'h0, "R4");
        // R6: lower nibbles of 0x55 / 0x57 have no effect
        wr(8'h55, 8'h7F, 4'h1, "R6"); hold(4'h1, "R6");
        wr(8'h57, 8'h2F, 4'h9, "R6"); hold(4'h9, "R6");
        wr(8'h57, 8'h20, 4'h8, "R6"); hold(4'h8, "R6");
        // R5: pins B and C through 0x56
        wr(8'h56, 8'hB4, 4'h0, "R5");
        hold(4'h2, "R5"); hold(4'h4, "R5"); hold(4'h6, "R5");
        // R7: all four pins on line 9
        wr(8'h55, 8'h90, 4'h0, "R7"); wr(8'h56, 8'h99, 4'h0, "R7");
        wr(8'h57, 8'h90, 4'h0, "R7");
        hold(4'hF, "R7"); hold(4'hE, "R7"); hold(4'hC, "R7");
        hold(4'h8, "R7"); hold(4'h0, "R7");
        for (int p = 0; p < 4; p++) hold(4'(1 << p), "R7");
        // R8: unmapped lines low while pins map to line 15 only
        wr(8'h55, 8'hF0, 4'h0, "R8"); wr(8'h56, 8'hFF, 4'h0, "R8");
        wr(8'h57, 8'hF0, 4'h0, "R8"); hold(4'hF, "R8");
        // R10: A and B on line 4; move A to 5 then B to 6
        wr(8'h55, 8'h40, 4'h0, "R10"); wr(8'h56, 8'h04, 4'h0, "R10");
        wr(8'h57, 8'h00, 4'h3, "R10"); hold(4'h3, "R10");
        wr(8'h55, 8'h50, 4'h3, "R10"); hold(4'h3, "R10");
        wr(8'h56, 8'h06, 4'h3, "R10"); hold(4'h3, "R10");
        // R7/R10: random writes and pin changes
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] ra;
            ra = 8'h54 + 8'($urandom_range(0, 4));
            step(ra, 8'($urandom), ($urandom_range(0, 3) == 0), 4'($urandom), "R7");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule